// File: doc/BRIEF.md
# Indirect Buffer RAM Window

This block gives a microcontroller byte access to a 2 KB on-chip buffer RAM through three registers on an 8-bit register bus. Two pointer registers together form an 11-bit buffer address: one holds the low eight bits, the other holds the top three bits in its least significant positions. A third register is the data window. Writing it stores a byte at the current pointer, and reading it returns the byte stored there. Either access then moves the pointer up by one, so a block of bytes can be streamed with repeated accesses to one offset.

Read data is registered. It appears on `reg_rdata` in the cycle after the read strobe and stays there until the next accepted read. The RAM has a synchronous read port. That port is always addressed with the pointer value that the current cycle will leave behind. As a result, the byte under the pointer is already fetched whenever a data read arrives, even right after a pointer write or a previous data access. The RAM array is inside the block. The register offsets are parameters, with defaults 0xA1 (low pointer), 0xA2 (high pointer) and 0xA3 (data window). There is no state machine: the only sequential state is the pointer, the fetched byte and the read-data register.

Top module: `bufram_window`

## Requirements
- R1: After reset the pointer is 0x000 and `reg_rdata` is 0x00.
- R2: A write to offset 0xA1 replaces pointer bits [7:0] and leaves bits [10:8] unchanged. A read of offset 0xA1 returns pointer bits [7:0].
- R3: A write to offset 0xA2 loads `reg_wdata[2:0]` into pointer bits [10:8] and leaves bits [7:0] unchanged. A read of offset 0xA2 returns bits [10:8] in positions [2:0], with bits [7:3] always zero.
- R4: A write to offset 0xA3 stores `reg_wdata` at the RAM location named by the pointer, then raises the pointer by one.
- R5: A read of offset 0xA3 returns the byte at the pointer value held before the access, then raises the pointer by one. Data reads on consecutive cycles each return the correct byte, with no gap.
- R6: When the low pointer byte steps from 0xFF to 0x00, the upper three bits rise by one.
- R7: The pointer steps from 0x7FF to 0x000.
- R8: A data access in the cycle right after a pointer write uses the newly written pointer.
- R9: A read of any other offset returns 0x00. A write to any other offset changes neither the pointer nor the RAM.
- R10: When both strobes are asserted in the same cycle, only the write is performed, and `reg_rdata` keeps its previous value.
- R11: `reg_rdata` changes only in the cycle after an accepted read. A read of a pointer register does not move the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register offset for the access |
| reg_wdata | input | 8 | Data for a register write |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_rdata | output | 8 | Registered read data, valid in the cycle after a read strobe |

## Verification
The bench streams bytes with back-to-back data reads, including reads right after a pointer write. A design that fetched the RAM from the old pointer would return the previous byte, or the byte one step ahead. The bench also steps the pointer across the 0x0FF→0x100 and 0x7FF→0x000 boundaries. A missing carry would jump back to the start of the page, and a wrong wrap would go past the array. It writes ones into the reserved high-pointer bits, which a careless design would echo on read. It checks accesses to undecoded offsets and accesses with both strobes asserted, where a wrong design would move the pointer or overwrite the read-data register.

// File: rtl/bufwin_pkg.sv
package bufwin_pkg;
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_LO   = 2'd1,
        SEL_HI   = 2'd2,
        SEL_DATA = 2'd3
    } win_sel_e;
endpackage

// File: rtl/bufwin_decode.sv
module bufwin_decode
    import bufwin_pkg::*;
#(
    parameter int REG_AW = 8,
    parameter logic [REG_AW-1:0] OFS_LO   = 8'hA1,
    parameter logic [REG_AW-1:0] OFS_HI   = 8'hA2,
    parameter logic [REG_AW-1:0] OFS_DATA = 8'hA3
) (
    input  logic [REG_AW-1:0] reg_addr,
    output win_sel_e          sel
);
    always_comb begin
        if (reg_addr == OFS_LO)        sel = SEL_LO;
        else if (reg_addr == OFS_HI)   sel = SEL_HI;
        else if (reg_addr == OFS_DATA) sel = SEL_DATA;
        else                           sel = SEL_NONE;
    end
endmodule

// File: rtl/bufwin_ptr.sv
module bufwin_ptr
    import bufwin_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  win_sel_e          sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [ADDR_W-1:0] ptr_q,
    output logic [ADDR_W-1:0] ptr_d
);
    localparam int HI_W = ADDR_W - DATA_W;

    logic step;

    assign step = (wr_en || rd_en) && (sel == SEL_DATA);

    always_comb begin
        ptr_d = ptr_q;
        if (step) begin
            ptr_d = ptr_q + ADDR_W'(1);
        end else if (wr_en && sel == SEL_LO) begin
            ptr_d[DATA_W-1:0] = wdata;
        end else if (wr_en && sel == SEL_HI) begin
            ptr_d[ADDR_W-1:DATA_W] = wdata[HI_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    // Each data access moves the pointer up by exactly one (R4, R5)
    assert_data_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (ptr_q == $past(ptr_q) + ADDR_W'(1)));

    // The top pointer value rolls over to zero (R7)
    assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && (&ptr_q)) |=> (ptr_q == '0));

    // A high-pointer write leaves the low byte alone (R3)
    assert_hi_keeps_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_HI) |=> (ptr_q[DATA_W-1:0] == $past(ptr_q[DATA_W-1:0])));

    // Undecoded offsets and pointer reads leave the pointer unchanged (R9, R11)
    assert_ptr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_NONE || (rd_en && sel != SEL_DATA)) |=> $stable(ptr_q));
endmodule

// File: rtl/bufwin_ram.sv
module bufwin_ram #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/bufram_window.sv
module bufram_window
    import bufwin_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8,
    parameter int REG_AW = 8,
    parameter logic [REG_AW-1:0] OFS_LO   = 8'hA1,
    parameter logic [REG_AW-1:0] OFS_HI   = 8'hA2,
    parameter logic [REG_AW-1:0] OFS_DATA = 8'hA3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_wr,
    input  logic              reg_rd,
    output logic [DATA_W-1:0] reg_rdata
);
    localparam int HI_W = ADDR_W - DATA_W;

    win_sel_e          sel;
    logic              rd_en;
    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] ptr_d;
    logic [DATA_W-1:0] ram_q;
    logic              ram_we;

    assign rd_en  = reg_rd && !reg_wr;
    assign ram_we = reg_wr && (sel == SEL_DATA);

    bufwin_decode #(
        .REG_AW   (REG_AW),
        .OFS_LO   (OFS_LO),
        .OFS_HI   (OFS_HI),
        .OFS_DATA (OFS_DATA)
    ) u_decode (
        .reg_addr (reg_addr),
        .sel      (sel)
    );

    bufwin_ptr #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (sel),
        .wr_en (reg_wr),
        .rd_en (rd_en),
        .wdata (reg_wdata),
        .ptr_q (ptr_q),
        .ptr_d (ptr_d)
    );

    // The read port follows the pointer value this cycle leaves behind,
    // so the byte under the pointer is always fetched ahead of a read.
    bufwin_ram #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ptr_q),
        .wdata (reg_wdata),
        .raddr (ptr_d),
        .rdata (ram_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (rd_en) begin
            case (sel)
                SEL_LO:   reg_rdata <= ptr_q[DATA_W-1:0];
                SEL_HI:   reg_rdata <= DATA_W'(ptr_q[ADDR_W-1:DATA_W]);
                SEL_DATA: reg_rdata <= ram_q;
                default:  reg_rdata <= '0;
            endcase
        end
    end

    // Reserved high-pointer bits never read back as one (R3)
    assert_hi_reserved_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_HI) |=> (reg_rdata[DATA_W-1:HI_W] == '0));

    // Undecoded reads return zero (R9)
    assert_undecoded_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_NONE) |=> (reg_rdata == '0));

    // With both strobes asserted the read is dropped (R10)
    assert_dual_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_wr) |=> $stable(reg_rdata));

    // Read data holds unless a read was accepted (R11)
    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(reg_rdata));
endmodule

// File: tb/bufram_window_bench.sv
module bufram_window_bench;
    localparam logic [7:0] A_LO = 8'hA1;
    localparam logic [7:0] A_HI = 8'hA2;
    localparam logic [7:0] A_DT = 8'hA3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_rdata;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    live = 0;
    bit    done = 0;
    string cur_req = "R1";

    int m_mem [2048];
    int m_ptr = 0;
    int m_rdata = 0;

    always #4 clk = ~clk;

    bufram_window u_bufram_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_rdata (reg_rdata)
    );

    // Behavioural reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ptr = 0;
            m_rdata = 0;
        end else if (reg_wr) begin
            if (reg_addr == A_LO)      m_ptr = (m_ptr & 32'h700) | int'(reg_wdata);
            else if (reg_addr == A_HI) m_ptr = (m_ptr & 32'hFF) | (int'(reg_wdata & 8'h07) << 8);
            else if (reg_addr == A_DT) begin
                m_mem[m_ptr] = int'(reg_wdata);
                m_ptr = (m_ptr + 1) % 2048;
            end
        end else if (reg_rd) begin
            if (reg_addr == A_LO)      m_rdata = m_ptr & 255;
            else if (reg_addr == A_HI) m_rdata = m_ptr >> 8;
            else if (reg_addr == A_DT) begin
                m_rdata = m_mem[m_ptr];
                m_ptr = (m_ptr + 1) % 2048;
            end else m_rdata = 0;
        end
    end

    // Compare every clock, away from the active edge
    always @(negedge clk) begin
        if (live && !done) begin
            n_chk++;
            if (int'(reg_rdata) != m_rdata) begin
                n_fail++;
                $display("FAIL %s: reg_rdata actual %02h expected %02h", cur_req, reg_rdata, m_rdata[7:0]);
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1; reg_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a);
        reg_addr = a; reg_wr = 1'b0; reg_rd = 1'b1;
        @(negedge clk);
    endtask

    task automatic idle();
        reg_wr = 1'b0; reg_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_ptr(input int p);
        wr(A_LO, 8'(p & 255));
        wr(A_HI, 8'(p >> 8));
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 2048; i++) m_mem[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        live = 1;
        // R1: reset state
        cur_req = "R1";
        chk("R1 rdata", reg_rdata, 8'h00);
        rd(A_LO); chk("R1 low ptr", reg_rdata, 8'h00);
        rd(A_HI); chk("R1 high ptr", reg_rdata, 8'h00);
        idle();

        // R4, R7: fill the whole array, pointer wraps back to zero
        cur_req = "R4";
        for (int i = 0; i < 2048; i++) wr(A_DT, 8'((i * 7 + 3) & 255));
        cur_req = "R7";
        rd(A_LO); chk("R7 low after fill", reg_rdata, 8'h00);
        rd(A_HI); chk("R7 high after fill", reg_rdata, 8'h00);

        // R2: low pointer write leaves high bits
        cur_req = "R2";
        wr(A_HI, 8'h05); wr(A_LO, 8'h3C);
        rd(A_LO); chk("R2 low readback", reg_rdata, 8'h3C);
        rd(A_HI); chk("R2 high kept", reg_rdata, 8'h05);

        // R3: reserved bits of high pointer
        cur_req = "R3";
        wr(A_HI, 8'hFA);
        rd(A_HI); chk("R3 reserved zero", reg_rdata, 8'h02);
        rd(A_LO); chk("R3 low kept", reg_rdata, 8'h3C);

        // R5, R6: back-to-back reads across the low-byte carry
        cur_req = "R6";
        set_ptr(12'h0FE);
        rd(A_DT); chk("R5 byte 0FE", reg_rdata, 8'((12'h0FE * 7 + 3) & 255));
        rd(A_DT); chk("R5 byte 0FF", reg_rdata, 8'((12'h0FF * 7 + 3) & 255));
        rd(A_DT); chk("R6 byte 100", reg_rdata, 8'((12'h100 * 7 + 3) & 255));
        rd(A_HI); chk("R6 high carry", reg_rdata, 8'h01);
        rd(A_LO); chk("R6 low after carry", reg_rdata, 8'h01);

        // R7: reads across the top of the array
        cur_req = "R7";
        set_ptr(12'h7FE);
        rd(A_DT); rd(A_DT);
        chk("R7 byte 7FF", reg_rdata, 8'((12'h7FF * 7 + 3) & 255));
        rd(A_DT); chk("R7 byte 000", reg_rdata, 8'h03);

        // R4, R8: write then immediate read after a pointer write
        cur_req = "R8";
        set_ptr(12'h123);
        wr(A_DT, 8'hA5); wr(A_DT, 8'h5A);
        wr(A_LO, 8'h23); rd(A_DT);
        chk("R8 read after ptr write", reg_rdata, 8'hA5);
        rd(A_DT); chk("R4 second byte", reg_rdata, 8'h5A);

        // R9: undecoded offsets
        cur_req = "R9";
        wr(8'h10, 8'h77); wr(8'hA0, 8'h77); wr(8'hA4, 8'h77);
        rd(8'hA4); chk("R9 undecoded read", reg_rdata, 8'h00);
        rd(A_LO); chk("R9 ptr unchanged", reg_rdata, 8'h25);

        // R10: both strobes -> write only
        cur_req = "R10";
        set_ptr(12'h040);
        rd(A_LO);
        reg_addr = A_DT; reg_wdata = 8'hC3; reg_wr = 1'b1; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0; reg_wr = 1'b0;
        chk("R10 rdata held", reg_rdata, 8'h40);
        rd(A_LO); chk("R10 ptr stepped once", reg_rdata, 8'h41);
        set_ptr(12'h040);
        rd(A_DT); chk("R10 byte written", reg_rdata, 8'hC3);

        // R11: hold between reads
        cur_req = "R11";
        idle(); idle();
        chk("R11 held", reg_rdata, 8'hC3);
        rd(A_LO); rd(A_LO); chk("R11 ptr read no step", reg_rdata, 8'h41);
        idle();
        finish_run();
    end
endmodule